// File: doc/BRIEF.md
# Program Flow Sequencer

This block keeps the fetch address of a small microcontroller core and moves it forward one instruction per fetch strobe. Next to the fetch address it holds a writable interrupt entry address and two loop counters. Each of the four can be read or written through a narrow register port that picks one of them by a 3-bit index. A write to the fetch address sends program flow elsewhere. Reading any of them has no side effect.

When the core acknowledges an interrupt, the block performs a call. The fetch address is replaced by the entry address. On the next cycle a single-cycle push request appears, carrying the address that would have been fetched next. Stack storage is outside the block. A loop instruction names one of the two counters and supplies a branch target. The selected counter is first reduced by one. The branch is taken only if the reduced value is not zero; otherwise the fetch address carries on as it would have without the loop instruction.

Top module: `flow_sequencer`

## Requirements
- R1: After reset the fetch address is 8000h, the interrupt entry address and both loop counters read 0000h, and the push request is low.
- R2: A fetch strobe alone advances the fetch address by exactly 1 on the next clock, wrapping from FFFFh to 0000h.
- R3: A register write with index 0 loads the fetch address with the write data on the next clock. It takes priority over a fetch, an interrupt acknowledge and a taken loop branch in the same cycle, and it cancels that cycle's call.
- R4: Register reads are combinational and change no state: with no fetch, write, acknowledge or loop operation, the fetch address holds.
- R5: Index 1 is the interrupt entry address, readable and writable. Indices 4 to 7 read as 0000h, and writes to them change nothing.
- R6: An interrupt acknowledge without an index-0 write loads the fetch address with the entry address value that held before the clock edge. This happens even if the same cycle writes a new entry address, and it takes priority over a taken loop branch and a fetch.
- R7: One clock after an acknowledge that performs a call, the push request is high for that one cycle, and the push address equals the fetch address as it stood in the acknowledge cycle. In every other cycle the push request is low.
- R8: Index 2 is loop counter 0 and index 3 is loop counter 1. Both are 16 bits wide and readable and writable.
- R9: A loop operation with counter select 0 or 1 decrements that counter by one, wrapping 0000h to FFFFh, and leaves the other counter unchanged.
- R10: A loop operation jumps to the branch target when the decremented value is non-zero. When the decremented value is zero, the fetch address follows the fetch strobe as if no loop operation had been issued.
- R11: A register write to a counter in the same cycle as a loop operation on that counter stores the written value. The branch decision still uses the old value minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Program fetch strobe |
| irq_ack_i | input | 1 | Interrupt acknowledge, triggers a call |
| reg_wr_i | input | 1 | Register write enable |
| reg_sel_i | input | 3 | Register index (0 fetch addr, 1 entry addr, 2/3 counters) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_sel_i |
| loop_en_i | input | 1 | Loop decrement-and-branch request |
| loop_sel_i | input | 1 | Counter used by the loop operation |
| loop_target_i | input | 16 | Branch target of the loop operation |
| ip_o | output | 16 | Current fetch address |
| push_req_o | output | 1 | One-cycle stack push request |
| push_addr_o | output | 16 | Return address to push |

## Verification
Any corruption of the fetch address shows on ip_o on the very next clock. The bench compares that port every cycle, so a bad increment, a lost redirect or a wrong priority is seen within one cycle of its cause. A wrong entry address or counter value stays hidden until it is read back or used. It is used when an acknowledge jumps to the entry address, or when a loop operation takes or skips its branch. For that reason every setup in the bench is followed by a read or by the operation that consumes the value. The push port is checked in every cycle, so a missing, doubled or stale push request is caught one cycle after the acknowledge.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

    localparam int SEL_W = 3;

    // register index map of the read/write port
    typedef enum logic [SEL_W-1:0] {
        REG_IP   = 3'd0,
        REG_VEC  = 3'd1,
        REG_CNT0 = 3'd2
    } reg_code_e;

    // index of loop counter i (counters are consecutive from REG_CNT0)
    function automatic logic [SEL_W-1:0] cnt_code(input int idx);
        return SEL_W'(int'(REG_CNT0) + idx);
    endfunction

endpackage

// File: rtl/flow_reg_decode.sv
module flow_reg_decode
    import flow_seq_pkg::*;
#(
    parameter int W      = 16,
    parameter int N_LOOP = 2
) (
    input  logic                       wr_i,
    input  logic [SEL_W-1:0]           sel_i,
    input  logic [W-1:0]               ip_i,
    input  logic [W-1:0]               vec_i,
    input  logic [N_LOOP-1:0][W-1:0]   cnt_i,
    output logic                       wr_ip_o,
    output logic                       wr_vec_o,
    output logic [N_LOOP-1:0]          wr_cnt_o,
    output logic [W-1:0]               rdata_o
);

    always_comb begin
        wr_ip_o  = wr_i && (sel_i == REG_IP);
        wr_vec_o = wr_i && (sel_i == REG_VEC);
        for (int i = 0; i < N_LOOP; i++) begin
            wr_cnt_o[i] = wr_i && (sel_i == cnt_code(i));
        end
    end

    // unmapped indices read as zero
    always_comb begin
        rdata_o = '0;
        if (sel_i == REG_IP)  rdata_o = ip_i;
        if (sel_i == REG_VEC) rdata_o = vec_i;
        for (int i = 0; i < N_LOOP; i++) begin
            if (sel_i == cnt_code(i)) rdata_o = cnt_i[i];
        end
    end

    always_comb begin
        assert ($countones({wr_ip_o, wr_vec_o, wr_cnt_o}) <= 1)
            else $error("AST_ONE_WRITE_TARGET"); // R5
    end

endmodule

// File: rtl/flow_loop_unit.sv
module flow_loop_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         taken_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic [W-1:0] dec_val;

    always_comb begin
        dec_val = st_q.cnt - ONE;
        st_d    = st_q;
        if (wr_i)      st_d.cnt = wdata_i;   // write wins over the loop op
        else if (op_i) st_d.cnt = dec_val;
        taken_o = op_i && (dec_val != '0);    // decrement first, then test
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i && !wr_i) |=> (cnt_o == $past(cnt_o) - ONE)); // R9
    AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wdata_i))); // R11
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_i && !wr_i) |=> $stable(cnt_o)); // R9

endmodule

// File: rtl/flow_pc_unit.sv
module flow_pc_unit #(
    parameter int           W       = 16,
    parameter logic [W-1:0] IP_RST  = 16'h8000,
    parameter logic [W-1:0] VEC_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fetch_i,
    input  logic         irq_ack_i,
    input  logic         wr_ip_i,
    input  logic         wr_vec_i,
    input  logic [W-1:0] wdata_i,
    input  logic         loop_taken_i,
    input  logic [W-1:0] target_i,
    output logic [W-1:0] ip_o,
    output logic [W-1:0] vec_o,
    output logic         push_req_o,
    output logic [W-1:0] push_addr_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] ip;
        logic [W-1:0] vec;
        logic         push;
        logic [W-1:0] ret;
    } pc_st_t;

    pc_st_t st_d, st_q;
    logic   do_call;

    always_comb begin
        do_call = irq_ack_i && !wr_ip_i;
        st_d    = st_q;
        st_d.push = 1'b0;
        // priority: direct write, call, taken loop branch, fetch
        if (wr_ip_i)           st_d.ip = wdata_i;
        else if (irq_ack_i)    st_d.ip = st_q.vec;
        else if (loop_taken_i) st_d.ip = target_i;
        else if (fetch_i)      st_d.ip = st_q.ip + ONE;
        if (do_call) begin
            st_d.push = 1'b1;
            st_d.ret  = st_q.ip;
        end
        if (wr_vec_i) st_d.vec = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ip   <= IP_RST;
            st_q.vec  <= VEC_RST;
            st_q.push <= 1'b0;
            st_q.ret  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ip_o        = st_q.ip;
    assign vec_o       = st_q.vec;
    assign push_req_o  = st_q.push;
    assign push_addr_o = st_q.ret;

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !wr_ip_i && !irq_ack_i && !loop_taken_i)
            |=> (ip_o == $past(ip_o) + ONE)); // R2
    AST_WRITE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ip_i |=> (ip_o == $past(wdata_i))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_i && !wr_ip_i && !irq_ack_i && !loop_taken_i) |=> $stable(ip_o)); // R4
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vec_i |=> $stable(vec_o)); // R5
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !wr_ip_i) |=> (ip_o == $past(vec_o))); // R6
    AST_PUSH_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !wr_ip_i) |=> (push_req_o && push_addr_o == $past(ip_o))); // R7
    AST_NO_STRAY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack_i && !wr_ip_i) |=> !push_req_o); // R7

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
    import flow_seq_pkg::*;
#(
    parameter int           W       = 16,
    parameter int           N_LOOP  = 2,
    parameter logic [W-1:0] IP_RST  = 16'h8000,
    parameter logic [W-1:0] VEC_RST = '0,
    localparam int          LSEL_W  = (N_LOOP > 1) ? $clog2(N_LOOP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic              irq_ack_i,
    input  logic              reg_wr_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [W-1:0]      reg_wdata_i,
    output logic [W-1:0]      reg_rdata_o,
    input  logic              loop_en_i,
    input  logic [LSEL_W-1:0] loop_sel_i,
    input  logic [W-1:0]      loop_target_i,
    output logic [W-1:0]      ip_o,
    output logic              push_req_o,
    output logic [W-1:0]      push_addr_o
);

    logic                     wr_ip, wr_vec;
    logic [N_LOOP-1:0]        wr_cnt, cnt_op, cnt_taken;
    logic [N_LOOP-1:0][W-1:0] cnt_val;
    logic [W-1:0]             vec_val;
    logic                     loop_taken;

    flow_reg_decode #(.W(W), .N_LOOP(N_LOOP)) u_decode (
        .wr_i     (reg_wr_i),
        .sel_i    (reg_sel_i),
        .ip_i     (ip_o),
        .vec_i    (vec_val),
        .cnt_i    (cnt_val),
        .wr_ip_o  (wr_ip),
        .wr_vec_o (wr_vec),
        .wr_cnt_o (wr_cnt),
        .rdata_o  (reg_rdata_o)
    );

    for (genvar g = 0; g < N_LOOP; g++) begin : g_loop
        assign cnt_op[g] = loop_en_i && (loop_sel_i == LSEL_W'(g));
        flow_loop_unit #(.W(W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_i    (cnt_op[g]),
            .wr_i    (wr_cnt[g]),
            .wdata_i (reg_wdata_i),
            .cnt_o   (cnt_val[g]),
            .taken_o (cnt_taken[g])
        );
    end

    assign loop_taken = |cnt_taken;

    flow_pc_unit #(.W(W), .IP_RST(IP_RST), .VEC_RST(VEC_RST)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_i      (fetch_i),
        .irq_ack_i    (irq_ack_i),
        .wr_ip_i      (wr_ip),
        .wr_vec_i     (wr_vec),
        .wdata_i      (reg_wdata_i),
        .loop_taken_i (loop_taken),
        .target_i     (loop_target_i),
        .ip_o         (ip_o),
        .vec_o        (vec_val),
        .push_req_o   (push_req_o),
        .push_addr_o  (push_addr_o)
    );

    AST_LOOP_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_taken && !wr_ip && !irq_ack_i) |=> (ip_o == $past(loop_target_i))); // R10
    AST_SINGLE_LOOP_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_op)); // R9

endmodule

// File: tb/tb_flow_sequencer.sv
module tb_flow_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_i = 1'b0, irq_ack_i = 1'b0, reg_wr_i = 1'b0;
    logic [2:0]  reg_sel_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        loop_en_i = 1'b0;
    logic [0:0]  loop_sel_i = '0;
    logic [15:0] loop_target_i = '0;
    logic [15:0] ip_o, push_addr_o;
    logic        push_req_o;

    flow_sequencer dut (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .irq_ack_i(irq_ack_i),
        .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .loop_en_i(loop_en_i), .loop_sel_i(loop_sel_i),
        .loop_target_i(loop_target_i), .ip_o(ip_o), .push_req_o(push_req_o),
        .push_addr_o(push_addr_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [15:0] ip;
        logic        push;
        logic [15:0] paddr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0, n_bad = 0;
    logic [15:0] m_ip = 16'h8000, m_vec = '0;
    logic [15:0] m_c [2] = '{16'h0, 16'h0};

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // monitor: one expected item per clock
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "ip", ip_o, e.ip);
            chk(e.tag, "push_req", {15'd0, push_req_o}, {15'd0, e.push});
            if (e.push) chk(e.tag, "push_addr", push_addr_o, e.paddr);
        end
    end

    // driver: applies one cycle, predicts the result from the requirements
    task automatic step(input logic f, input logic irq, input logic wr,
                        input logic [2:0] sel, input logic [15:0] wd,
                        input logic le, input logic ls, input logic [15:0] tgt,
                        input string tag);
        logic [15:0] n_ip, n_vec, dec;
        logic [15:0] n_c [2];
        logic        taken, wip, call;
        exp_t        e;
        fetch_i = f; irq_ack_i = irq; reg_wr_i = wr; reg_sel_i = sel;
        reg_wdata_i = wd; loop_en_i = le; loop_sel_i = ls; loop_target_i = tgt;
        wip   = wr && sel == 3'd0;
        call  = irq && !wip;
        dec   = m_c[ls] - 16'd1;
        taken = le && dec != 16'd0;
        n_ip  = wip ? wd : irq ? m_vec : taken ? tgt : f ? m_ip + 16'd1 : m_ip;
        n_vec = (wr && sel == 3'd1) ? wd : m_vec;
        for (int i = 0; i < 2; i++) begin
            n_c[i] = (wr && sel == 3'(i + 2)) ? wd
                   : (le && ls == 1'(i)) ? m_c[i] - 16'd1 : m_c[i];
        end
        e.ip = n_ip; e.push = call; e.paddr = m_ip; e.tag = tag;
        @(posedge clk);
        #1;
        sb.push_back(e);
        m_ip = n_ip; m_vec = n_vec; m_c[0] = n_c[0]; m_c[1] = n_c[1];
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 3'd0, 16'h0, 0, 0, 16'h0, tag);
    endtask

    task automatic rd(input logic [2:0] sel, input logic [15:0] exp, input string tag);
        fetch_i = 0; irq_ack_i = 0; reg_wr_i = 0; loop_en_i = 0; reg_sel_i = sel;
        #1;
        chk(tag, "rdata", reg_rdata_o, exp);
        step(0, 0, 0, sel, 16'h0, 0, 0, 16'h0, tag);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d, input string tag);
        step(0, 0, 1, sel, d, 0, 0, 16'h0, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "ip", ip_o, 16'h8000);
        chk("R1", "push_req", {15'd0, push_req_o}, 16'h0);
        rd(3'd0, 16'h8000, "R1");
        rd(3'd1, 16'h0000, "R1");
        rd(3'd2, 16'h0000, "R1");
        rd(3'd3, 16'h0000, "R1");

        // R2: sequential fetch and wrap
        repeat (3) step(1, 0, 0, 3'd0, 0, 0, 0, 0, "R2");
        wr(3'd0, 16'hFFFF, "R3");
        step(1, 0, 0, 3'd0, 0, 0, 0, 0, "R2");
        rd(3'd0, 16'h0000, "R2");

        // R3: write beats fetch
        step(1, 0, 1, 3'd0, 16'h4321, 0, 0, 0, "R3");
        // R4: repeated reads, no movement
        repeat (3) rd(3'd0, 16'h4321, "R4");
        idle("R4");

        // R5: entry address and unmapped indices
        wr(3'd1, 16'h1234, "R5");
        rd(3'd1, 16'h1234, "R5");
        wr(3'd5, 16'hDEAD, "R5");
        rd(3'd5, 16'h0000, "R5");
        rd(3'd7, 16'h0000, "R5");
        rd(3'd1, 16'h1234, "R5");
        rd(3'd0, 16'h4321, "R5");
        rd(3'd2, 16'h0000, "R5");

        // R6/R7: call beats fetch, push follows
        step(1, 1, 0, 3'd0, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 3'd0, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 3'd0, 0, 0, 0, 0, "R7");
        // call uses old entry address despite same-cycle write
        step(0, 1, 1, 3'd1, 16'h2222, 0, 0, 0, "R6");
        idle("R7");
        rd(3'd1, 16'h2222, "R5");
        // write to fetch address cancels the call
        step(0, 1, 1, 3'd0, 16'h0100, 0, 0, 0, "R3");
        idle("R7");

        // R8-R10: loop counter 0 from 3
        wr(3'd2, 16'h0003, "R8");
        wr(3'd3, 16'h0055, "R8");
        rd(3'd2, 16'h0003, "R8");
        rd(3'd3, 16'h0055, "R8");
        step(1, 0, 0, 3'd0, 0, 1, 0, 16'hA000, "R10");
        step(1, 0, 0, 3'd0, 0, 1, 0, 16'hA000, "R10");
        step(1, 0, 0, 3'd0, 0, 1, 0, 16'hA000, "R10");
        rd(3'd2, 16'h0000, "R9");
        step(0, 0, 0, 3'd0, 0, 1, 0, 16'hB000, "R9");
        rd(3'd2, 16'hFFFF, "R9");
        rd(3'd3, 16'h0055, "R9");
        // counter 1 reaching zero without fetch: address holds
        wr(3'd3, 16'h0001, "R8");
        step(0, 0, 0, 3'd0, 0, 1, 1, 16'hC000, "R10");
        rd(3'd3, 16'h0000, "R9");
        // R11: write wins, branch uses old value minus one
        wr(3'd3, 16'h0001, "R11");
        step(0, 0, 1, 3'd3, 16'h0009, 1, 1, 16'hD000, "R11");
        rd(3'd3, 16'h0009, "R11");
        step(0, 0, 1, 3'd2, 16'h0007, 1, 0, 16'hD100, "R11");
        rd(3'd2, 16'h0007, "R11");
        // R6: call beats taken loop branch
        step(1, 1, 0, 3'd0, 0, 1, 0, 16'hE000, "R6");
        idle("R7");
        rd(3'd2, 16'h0006, "R9");

        // mixed stimulus
        for (int k = 0; k < 300; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[3:1] == 3'd5, lf[6:4] == 3'd2, lf[9:7], {lf[7:0], lf[15:8]},
                 lf[10], lf[11], {lf[3:0], lf[15:4]}, "R10");
        end
        idle("R4");
        rd(3'd0, m_ip, "R4");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule